// File: doc/BRIEF.md
# Paged Halfword-to-Word Register Bridge

This block is the slave end of a management access path. A host issues 16-bit register accesses over a parallel port. Each access carries a 5-bit device address, a 5-bit register number, a direction flag and write data. The bridge turns these accesses into 32-bit reads and writes on an internal register bus. The internal bus uses word addresses. The top nine word-address bits come from a page register that the host loads through one fixed device/register slot. The next three bits come from the low bits of a device address in a window of eight addresses. The lowest four bits come from the register number with its last bit dropped.

Each 32-bit internal register appears to the host as a pair of registers. The even register holds bits 15:0 and the odd register that follows it holds bits 31:16. Writes go high half first: the odd write only parks its data, and the even write sends one bus write that joins the parked half with the new low half. Reads go low half first: the even read fetches the whole word, returns bits 15:0 and parks bits 31:16. The following odd read returns the parked half, so both halves come from the same bus transfer.

The host-side port has no ready of its own. A request is taken in any cycle where `mg_busy` is low. `mg_busy` then stays high until a one-cycle `mg_ack`, and requests raised while busy are dropped. The internal bus is a valid/ready master. Once `bus_valid` rises, it stays high and the address, direction and write data stay constant until the cycle where `bus_ready` is sampled high. The memory side may hold `bus_ready` low for any number of cycles, and the host waits out that back-pressure through `mg_busy`. Read data on `bus_rdata` is taken in the handshake cycle.

Top module: `mdio_regbridge`

## Requirements
- R1: After reset `mg_busy`, `mg_ack` and `bus_valid` are 0, and the page register and both parked halves are 0. A read of the page slot or of any odd window register returns 0 until it is written.
- R2: A write to device address 0x1f, register 0x10 loads `mg_wdata[8:0]` into the page register without any bus transfer. A read of that slot returns the page zero-extended to 16 bits.
- R3: A bridged access uses bus word address {page[8:0], device[2:0], register[4:1]}. Device addresses 0x10 to 0x17 form the window.
- R4: A write to an odd register in the window parks its 16 bits as the pending high half and starts no bus transfer.
- R5: A write to an even register in the window starts exactly one bus write with `bus_we`=1 and `bus_wdata` = {pending high half, `mg_wdata`}. The pending high half keeps its value afterwards.
- R6: A read of an even register in the window starts exactly one bus read with `bus_we`=0. It returns `bus_rdata[15:0]` on `mg_rdata` and parks `bus_rdata[31:16]`.
- R7: A read of an odd register in the window returns the parked upper half without a bus transfer. Repeated odd reads return the same value.
- R8: Any access to a device address outside the window, other than the page slot, starts no bus transfer and changes no state. Such a read returns 0xffff.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, the next cycle keeps `bus_valid` at 1 with `bus_addr`, `bus_we` and `bus_wdata` unchanged.
- R10: A request is taken when `mg_req` is 1 and `mg_busy` is 0. `mg_busy` stays 1 until the single-cycle `mg_ack`, and requests raised while busy are ignored. A local access acks one cycle after it is taken. A bus access acks one cycle after the handshake, with read data valid on `mg_rdata` in the ack cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mg_req | input | 1 | Host access request |
| mg_wr | input | 1 | 1 = write, 0 = read |
| mg_phy | input | 5 | Device address of the access |
| mg_reg | input | 5 | Register number of the access |
| mg_wdata | input | 16 | Host write data |
| mg_busy | output | 1 | Access in progress, new requests dropped |
| mg_ack | output | 1 | One-cycle completion pulse |
| mg_rdata | output | 16 | Read result, valid with `mg_ack` on reads |
| bus_valid | output | 1 | Internal bus request valid |
| bus_ready | input | 1 | Internal bus accepts / completes request |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 16 | Internal bus word address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_rdata | input | 32 | Internal bus read data, taken with `bus_ready` |

## Verification
The bench first checks that a high-half write is joined with the next low-half write. A design that cleared the parked half, or that sent the odd write to the bus, would put the wrong upper word in memory. A later even write reuses the old parked half, which exposes a design that clears it after use. Odd reads after an even read must repeat the parked value, so a design that fetched the word again on the odd read would be caught. Bus stalls of zero to three cycles test the valid hold and the ack timing, and a request raised during a stall must not reach the page register. Out-of-window reads and writes, including the odd neighbour of the page slot, must return 0xffff and leave the page untouched.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_RESP
  } mrb_state_e;

  typedef enum logic [2:0] {
    K_PAGE_WR,
    K_PAGE_RD,
    K_HI_WR,
    K_HI_RD,
    K_BUS_WR,
    K_BUS_RD,
    K_VOID_WR,
    K_VOID_RD
  } mrb_kind_e;
endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mrb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter logic [PHY_W-1:0]       PAGE_PHY = 5'h1f,
  parameter logic [REG_W-1:0]       PAGE_REG = 5'h10,
  parameter logic [PHY_W-SEL_W-1:0] WIN_TAG  = 2'b10,
  localparam int AW = PAGE_W + SEL_W + REG_W - 1
) (
  input  logic              wr,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [PAGE_W-1:0] page,
  output mrb_kind_e         kind,
  output logic [AW-1:0]     word_addr
);
  logic in_win;
  logic is_page;

  always_comb begin
    in_win  = (phy[PHY_W-1:SEL_W] == WIN_TAG);
    is_page = (phy == PAGE_PHY) && (regn == PAGE_REG);
    if (is_page)
      kind = wr ? K_PAGE_WR : K_PAGE_RD;
    else if (!in_win)
      kind = wr ? K_VOID_WR : K_VOID_RD;
    else if (regn[0])
      kind = wr ? K_HI_WR : K_HI_RD;
    else
      kind = wr ? K_BUS_WR : K_BUS_RD;
    word_addr = {page, phy[SEL_W-1:0], regn[REG_W-1:1]};
  end
endmodule

// File: rtl/mrb_hold.sv
module mrb_hold
  import mrb_pkg::*;
#(
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_d,
  input  logic              hiw_we,
  input  logic [HALF_W-1:0] hiw_d,
  input  logic              hir_we,
  input  logic [HALF_W-1:0] hir_d,
  output logic [PAGE_W-1:0] page_q,
  output logic [HALF_W-1:0] hiw_q,
  output logic [HALF_W-1:0] hir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      hiw_q  <= '0;
      hir_q  <= '0;
    end else begin
      if (page_we) page_q <= page_d;
      if (hiw_we)  hiw_q  <= hiw_d;
      if (hir_we)  hir_q  <= hir_d;
    end
  end
endmodule

// File: rtl/mrb_ctrl.sv
module mrb_ctrl
  import mrb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  mrb_kind_e         kind,
  input  logic [AW-1:0]     word_addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [PAGE_W-1:0] page,
  input  logic [HALF_W-1:0] hiw,
  input  logic [HALF_W-1:0] hir,
  input  logic              bus_ready,
  input  logic [HALF_W-1:0] bus_rdata_lo,
  output logic              busy,
  output logic              ack,
  output logic [HALF_W-1:0] rdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic              page_we,
  output logic              hiw_we,
  output logic              hir_we
);
  mrb_state_e state;
  logic       take;

  always_comb begin
    take    = (state == ST_IDLE) && req;
    busy    = (state != ST_IDLE);
    ack     = (state == ST_RESP);
    page_we = take && (kind == K_PAGE_WR);
    hiw_we  = take && (kind == K_HI_WR);
    hir_we  = (state == ST_BUS) && bus_ready && !bus_we;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rdata     <= '0;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req) begin
            state <= ST_RESP;
            case (kind)
              K_BUS_WR: begin
                state     <= ST_BUS;
                bus_valid <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= word_addr;
                bus_wdata <= {hiw, wdata};
              end
              K_BUS_RD: begin
                state     <= ST_BUS;
                bus_valid <= 1'b1;
                bus_we    <= 1'b0;
                bus_addr  <= word_addr;
              end
              K_PAGE_RD: rdata <= {{(HALF_W-PAGE_W){1'b0}}, page};
              K_HI_RD:   rdata <= hir;
              K_VOID_RD: rdata <= '1;
              default:   ;
            endcase
          end
        end
        ST_BUS: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            if (!bus_we) rdata <= bus_rdata_lo;
            state <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regbridge.sv
module mdio_regbridge
  import mrb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  localparam int AW = PAGE_W + SEL_W + REG_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mg_req,
  input  logic              mg_wr,
  input  logic [PHY_W-1:0]  mg_phy,
  input  logic [REG_W-1:0]  mg_reg,
  input  logic [15:0]       mg_wdata,
  output logic              mg_busy,
  output logic              mg_ack,
  output logic [15:0]       mg_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  mrb_kind_e         kind;
  logic [AW-1:0]     word_addr;
  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] hiw_q;
  logic [HALF_W-1:0] hir_q;
  logic              page_we;
  logic              hiw_we;
  logic              hir_we;

  mrb_decode #(
    .PAGE_W(PAGE_W), .SEL_W(SEL_W), .PHY_W(PHY_W), .REG_W(REG_W)
  ) u_dec (
    .wr(mg_wr), .phy(mg_phy), .regn(mg_reg), .page(page_q),
    .kind(kind), .word_addr(word_addr)
  );

  mrb_hold #(.PAGE_W(PAGE_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .page_we(page_we), .page_d(mg_wdata[PAGE_W-1:0]),
    .hiw_we(hiw_we), .hiw_d(mg_wdata),
    .hir_we(hir_we), .hir_d(bus_rdata[31:16]),
    .page_q(page_q), .hiw_q(hiw_q), .hir_q(hir_q)
  );

  mrb_ctrl #(.PAGE_W(PAGE_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(mg_req), .kind(kind),
    .word_addr(word_addr), .wdata(mg_wdata), .page(page_q),
    .hiw(hiw_q), .hir(hir_q), .bus_ready(bus_ready),
    .bus_rdata_lo(bus_rdata[15:0]), .busy(mg_busy), .ack(mg_ack),
    .rdata(mg_rdata), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .page_we(page_we), .hiw_we(hiw_we), .hir_we(hir_we)
  );
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mg_req,
  input logic        mg_wr,
  input logic [4:0]  mg_phy,
  input logic [4:0]  mg_reg,
  input logic        mg_busy,
  input logic        mg_ack,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_we,
  input logic [6:0]  bus_addr_lo,
  input logic [31:0] bus_wdata
);
  logic take_win_even;
  logic take_outside;
  assign take_win_even = mg_req && !mg_busy && (mg_phy >= 5'h10) && (mg_phy <= 5'h17) && !mg_reg[0];
  assign take_outside  = mg_req && !mg_busy && ((mg_phy < 5'h10) || (mg_phy > 5'h17));

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr_lo) && $stable(bus_we) && $stable(bus_wdata))); // R9
  AST_BUSY_COVERS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (mg_busy && !mg_ack)); // R10
  AST_ACK_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> (mg_ack && !bus_valid)); // R10
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mg_ack |=> !mg_ack); // R10
  AST_EVEN_GOES_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    take_win_even |=> (bus_valid && bus_addr_lo == {$past(mg_phy[2:0]), $past(mg_reg[4:1])} && bus_we == $past(mg_wr))); // R3
  AST_ODD_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_req && !mg_busy && mg_reg[0]) |=> (!bus_valid && mg_ack)); // R4
  AST_OUTSIDE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    take_outside |=> (!bus_valid && mg_ack)); // R8
endmodule

bind mdio_regbridge mrb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mg_req(mg_req), .mg_wr(mg_wr),
  .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_busy(mg_busy), .mg_ack(mg_ack),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
  .bus_addr_lo(bus_addr[6:0]), .bus_wdata(bus_wdata)
);

// File: tb/mdio_regbridge_test.sv
module mdio_regbridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mg_req = 1'b0;
  logic        mg_wr = 1'b0;
  logic [4:0]  mg_phy = '0;
  logic [4:0]  mg_reg = '0;
  logic [15:0] mg_wdata = '0;
  logic        mg_busy, mg_ack;
  logic [15:0] mg_rdata;
  logic        bus_valid, bus_we;
  logic        bus_ready = 1'b0;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [8:0]  page_m = '0;
  logic [15:0] hiw_m = '0;
  logic [15:0] hir_m = '0;
  logic [31:0] mem_m [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_regbridge uut (
    .clk(clk), .rst_n(rst_n), .mg_req(mg_req), .mg_wr(mg_wr),
    .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_wdata(mg_wdata),
    .mg_busy(mg_busy), .mg_ack(mg_ack), .mg_rdata(mg_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [15:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return {a ^ 16'h5a5a, ~a};
  endfunction

  task automatic access(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, input int lat, input bit poke, input string tag);
    bit is_page = (phy == 5'h1f) && (rg == 5'h10);
    bit in_win  = (phy >= 5'h10) && (phy <= 5'h17);
    bit to_bus  = in_win && !rg[0];
    logic [15:0] a = {page_m, phy[2:0], rg[4:1]};
    logic [15:0] exp_rd = 16'hffff;
    logic [31:0] w;
    mg_req = 1'b1; mg_wr = wr; mg_phy = phy; mg_reg = rg; mg_wdata = d;
    @(negedge clk);
    mg_req = 1'b0;
    if (to_bus) begin
      chk(bus_valid == 1'b1, tag, {31'b0, bus_valid}, 32'd1);
      chk(bus_addr == a, "R3", {16'b0, bus_addr}, {16'b0, a});
      chk(bus_we == wr, tag, {31'b0, bus_we}, {31'b0, wr});
      if (wr) chk(bus_wdata == {hiw_m, d}, "R5", bus_wdata, {hiw_m, d});
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin
          mg_req = 1'b1; mg_wr = 1'b1; mg_phy = 5'h1f; mg_reg = 5'h10; mg_wdata = 16'h0155;
        end
        @(negedge clk);
        mg_req = 1'b0;
        chk(bus_valid && bus_addr == a && mg_busy && !mg_ack, "R9", {15'b0, bus_valid, bus_addr}, {16'h1, a});
      end
      w = word_of(a);
      bus_ready = 1'b1;
      bus_rdata = wr ? 32'hdead_0000 : w;
      @(negedge clk);
      bus_ready = 1'b0;
      if (wr) mem_m[int'(a)] = {hiw_m, d};
      else begin exp_rd = w[15:0]; hir_m = w[31:16]; end
      chk(mg_ack && mg_busy && !bus_valid, "R10", {29'b0, mg_ack, mg_busy, bus_valid}, 32'h6);
    end else begin
      chk(!bus_valid && mg_ack, tag, {30'b0, bus_valid, mg_ack}, 32'h1);
      if (is_page) begin
        if (wr) page_m = d[8:0];
        exp_rd = {7'b0, page_m};
      end else if (in_win) begin
        if (wr) hiw_m = d;
        exp_rd = hir_m;
      end
    end
    if (!wr) chk(mg_rdata == exp_rd, tag, {16'b0, mg_rdata}, {16'b0, exp_rd});
    @(negedge clk);
    chk(!mg_ack && !mg_busy, "R10", {30'b0, mg_ack, mg_busy}, 32'h0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mg_busy && !mg_ack && !bus_valid, "R1", {29'b0, mg_busy, mg_ack, bus_valid}, 32'h0);
    access(0, 5'h1f, 5'h10, 16'h0, 0, 0, "R1");
    access(0, 5'h10, 5'h01, 16'h0, 0, 0, "R1");
    access(1, 5'h10, 5'h04, 16'h00aa, 1, 0, "R1");
    access(1, 5'h1f, 5'h10, 16'hfdab, 0, 0, "R2");
    access(0, 5'h1f, 5'h10, 16'h0, 0, 0, "R2");
    access(1, 5'h13, 5'h05, 16'hbeef, 0, 0, "R4");
    access(1, 5'h13, 5'h04, 16'h1234, 2, 0, "R5");
    access(1, 5'h17, 5'h1e, 16'h4321, 0, 0, "R5");
    access(0, 5'h13, 5'h04, 16'h0, 3, 0, "R6");
    access(0, 5'h13, 5'h05, 16'h0, 0, 0, "R7");
    access(0, 5'h13, 5'h05, 16'h0, 0, 0, "R7");
    access(0, 5'h17, 5'h1e, 16'h0, 0, 0, "R6");
    access(0, 5'h17, 5'h1f, 16'h0, 0, 0, "R7");
    access(1, 5'h1f, 5'h10, 16'h0000, 0, 0, "R2");
    access(0, 5'h10, 5'h00, 16'h0, 1, 0, "R6");
    access(0, 5'h10, 5'h01, 16'h0, 0, 0, "R7");
    access(0, 5'h05, 5'h02, 16'h0, 0, 0, "R8");
    access(1, 5'h08, 5'h10, 16'h0077, 0, 0, "R8");
    access(1, 5'h1f, 5'h11, 16'h0066, 0, 0, "R8");
    access(0, 5'h1f, 5'h00, 16'h0, 0, 0, "R8");
    access(0, 5'h1f, 5'h10, 16'h0, 0, 0, "R8");
    access(0, 5'h14, 5'h0a, 16'h0, 3, 1, "R10");
    access(0, 5'h1f, 5'h10, 16'h0, 0, 0, "R10");
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule